// File: doc/BRIEF.md
# Loop and Rotation State Commit Unit

This block holds the loop and register-rotation state of a wide-issue processor and updates it at each bundle commit. It keeps a 64-bit loop status word, whose low 32 bits are a loop count and whose upper half carries a sticky overflow flag. It also keeps a rotating predicate base with its size, and a rotating register base with its size and a rotation base. The commit logic reads the bundle's control syllable and the resolved branch outcome. Each of three counters can be stepped, and each step is requested by one syllable bit for the taken outcome and a second bit for the not-taken outcome.

Direct loads set the status word, the predicate size and the register-base group from a set-instruction word. A load takes priority over a commit-time step of the same register in the same cycle. All state is registered: a commit or load presented in one cycle is visible on the outputs after the next rising clock edge. Every pin is a plain control or status signal. There is no valid/ready stream and no back-pressure, because the block accepts one commit per cycle and never stalls.

Top module: `loop_rot_commit`

## Requirements
- R1: After reset the status word, predicate base, predicate size, register base, register size and rotation base all read zero.
- R2: With `commit_valid` high, control bit 16 decrements the loop count (status bits 31:0) when `br_taken` is 1, and bit 17 does so when `br_taken` is 0. A bit whose outcome does not match has no effect.
- R3: A decrement of a loop count that is already zero leaves the count at zero and leaves the whole upper half of the status word unchanged.
- R4: A decrement of a count equal to one sets status bit 51 (the overflow flag), which then stays set. Decrements never change the other bits of 63:32.
- R5: With `commit_valid` high, control bit 18 steps the predicate base when taken, and bit 19 steps it when not taken.
- R6: A predicate step yields the minimum of (base − 1 modulo 64) and the predicate size, so a base of zero becomes the size.
- R7: With `commit_valid` high, control bit 21 (taken) or bit 22 (not taken) steps the register base. The step adds 2 modulo 256 and then subtracts the register size if the sum is greater than or equal to it.
- R8: `ld_rbase` loads base = 2×`set_word`[17:12], size = 2×`set_word`[11:6]+2 and rotation base = 2×`set_word`[5:0].
- R9: `ld_psize` loads the predicate size from `set_word`[23:18].
- R10: `ld_stat` loads the full 64-bit status word from `stat_data`.
- R11: A load beats a step of the same register in the same cycle. A predicate step taken with a size load in the same cycle uses the old size.
- R12: With `commit_valid` low and no load, no state changes. Control bits other than 16 to 19, 21 and 22 never change state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| commit_valid | input | 1 | A bundle commits this cycle |
| ctl_word | input | 32 | Control syllable of the committing bundle |
| br_taken | input | 1 | Resolved branch outcome, 1 = taken |
| ld_stat | input | 1 | Load the status word |
| stat_data | input | 64 | Status word to load |
| ld_rbase | input | 1 | Load the register-base group from set_word |
| ld_psize | input | 1 | Load the predicate size from set_word |
| set_word | input | 32 | Set-instruction word holding the load fields |
| stat_q | output | 64 | Loop status word |
| pbase_q | output | 6 | Rotating predicate base |
| psize_q | output | 6 | Predicate size |
| rbase_q | output | 8 | Rotating register base |
| rsize_q | output | 8 | Register size |
| rrot_q | output | 8 | Rotation base |

## Verification
Every result is due exactly one rising edge after its stimulus. The bench drives inputs on the falling edge and samples all six outputs 1 ns after the next rising edge, and then advances its own model. Directed cases cover the count-of-one, count-of-zero and base-of-zero boundaries, mismatched outcome bits, and loads that collide with steps. Constrained random commits follow the directed cases, with occasional loads, all checked against the same one-edge timing.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  localparam int STAT_W  = 64;
  localparam int CNT_W   = 32;
  localparam int OVF_POS = 51;
  localparam int FLD_W   = 6;
  localparam int PB_W    = 6;
  localparam int RB_W    = 8;
  localparam int CTL_W   = 32;
  localparam int N_TGT   = 3;

  typedef enum int {TGT_LOOP = 0, TGT_PRED = 1, TGT_REG = 2} tgt_e;

  function automatic int taken_pos(input int t);
    case (t)
      TGT_LOOP: taken_pos = 16;
      TGT_PRED: taken_pos = 18;
      default:  taken_pos = 21;
    endcase
  endfunction

  function automatic int nottaken_pos(input int t);
    nottaken_pos = taken_pos(t) + 1;
  endfunction
endpackage

// File: rtl/lrc_req_decode.sv
module lrc_req_decode
  import lrc_pkg::*;
#(
  parameter int CW = CTL_W,
  parameter int NT = N_TGT
) (
  input  logic          commit_valid,
  input  logic [CW-1:0] ctl_word,
  input  logic          br_taken,
  output logic [NT-1:0] step
);
  for (genvar t = 0; t < NT; t++) begin : g_tgt
    localparam int TKP = taken_pos(t);
    localparam int NTP = nottaken_pos(t);
    assign step[t] = commit_valid & (br_taken ? ctl_word[TKP] : ctl_word[NTP]);
  end
endmodule

// File: rtl/lrc_loop_ctr.sv
module lrc_loop_ctr #(
  parameter int SW  = 64,
  parameter int CW  = 32,
  parameter int OVP = 51
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_data,
  output logic [SW-1:0] stat_q
);
  localparam int HW = SW - CW;
  localparam logic [HW-1:0] OVF_MASK = {{(HW-1){1'b0}}, 1'b1} << (OVP - CW);

  logic [CW-1:0] cnt, cnt_m1, cnt_sat;
  logic          hit_one;
  logic [SW-1:0] stat_d;

  always_comb begin
    cnt     = stat_q[CW-1:0];
    cnt_m1  = cnt - CW'(1);
    cnt_sat = (cnt == '0) ? cnt : cnt_m1;
    hit_one = (cnt_m1 == '0);
    stat_d  = stat_q;
    if (ld_en) begin
      stat_d = ld_data;
    end else if (step) begin
      stat_d[CW-1:0] = cnt_sat;
      if (hit_one) stat_d[OVP] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  a_r3_sat_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_en && stat_q[CW-1:0] == '0) |=> (stat_q == $past(stat_q)));

  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && stat_q[OVP]) |=> stat_q[OVP]);

  a_r4_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en) |=> ((stat_q[SW-1:CW] | OVF_MASK) == ($past(stat_q[SW-1:CW]) | OVF_MASK)));

  a_r4_ovf_on_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_en && stat_q[CW-1:0] == CW'(1)) |=> (stat_q[OVP] && stat_q[CW-1:0] == '0));
endmodule

// File: rtl/lrc_pred_base.sv
module lrc_pred_base #(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          ld_size_en,
  input  logic [PW-1:0] ld_size,
  output logic [PW-1:0] base_q,
  output logic [PW-1:0] size_q
);
  logic [PW-1:0] base_m1, base_d, size_d;

  always_comb begin
    base_m1 = base_q - PW'(1);
    base_d  = base_q;
    if (step) base_d = (base_m1 < size_q) ? base_m1 : size_q;
    size_d  = ld_size_en ? ld_size : size_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
    end else begin
      base_q <= base_d;
      size_q <= size_d;
    end
  end

  a_r6_zero_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (step && base_q == '0) |=> (base_q == $past(size_q)));

  a_r6_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (base_q <= $past(size_q)));

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step) |=> $stable(base_q));
endmodule

// File: rtl/lrc_reg_base.sv
module lrc_reg_base #(
  parameter int RW = 8,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          ld_en,
  input  logic [FW-1:0] f_cur,
  input  logic [FW-1:0] f_size,
  input  logic [FW-1:0] f_rot,
  output logic [RW-1:0] base_q,
  output logic [RW-1:0] size_q,
  output logic [RW-1:0] rot_q
);
  logic [RW-1:0] stepped, wrapped, base_d, size_d, rot_d;

  always_comb begin
    stepped = base_q + RW'(2);
    wrapped = (stepped >= size_q) ? (stepped - size_q) : stepped;
    base_d  = base_q;
    size_d  = size_q;
    rot_d   = rot_q;
    if (ld_en) begin
      base_d = RW'(f_cur) << 1;
      size_d = (RW'(f_size) << 1) + RW'(2);
      rot_d  = RW'(f_rot) << 1;
    end else if (step) begin
      base_d = wrapped;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      rot_q  <= '0;
    end else begin
      base_q <= base_d;
      size_q <= size_d;
      rot_q  <= rot_d;
    end
  end

  a_r7_stays_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_en && size_q != '0 && base_q < size_q) |=> (base_q < size_q));

  a_r8_size_even_min: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (size_q >= RW'(2) && !size_q[0] && !base_q[0] && !rot_q[0]));

  a_r11_size_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en) |=> ($stable(size_q) && $stable(rot_q)));
endmodule

// File: rtl/loop_rot_commit.sv
module loop_rot_commit
  import lrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_valid,
  input  logic [CTL_W-1:0]  ctl_word,
  input  logic              br_taken,
  input  logic              ld_stat,
  input  logic [STAT_W-1:0] stat_data,
  input  logic              ld_rbase,
  input  logic              ld_psize,
  input  logic [31:0]       set_word,
  output logic [STAT_W-1:0] stat_q,
  output logic [PB_W-1:0]   pbase_q,
  output logic [PB_W-1:0]   psize_q,
  output logic [RB_W-1:0]   rbase_q,
  output logic [RB_W-1:0]   rsize_q,
  output logic [RB_W-1:0]   rrot_q
);
  logic [N_TGT-1:0] step;

  lrc_req_decode #(.CW(CTL_W), .NT(N_TGT)) u_dec (
    .commit_valid(commit_valid),
    .ctl_word    (ctl_word),
    .br_taken    (br_taken),
    .step        (step)
  );

  lrc_loop_ctr #(.SW(STAT_W), .CW(CNT_W), .OVP(OVF_POS)) u_loop (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step[TGT_LOOP]),
    .ld_en  (ld_stat),
    .ld_data(stat_data),
    .stat_q (stat_q)
  );

  lrc_pred_base #(.PW(PB_W)) u_pred (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step[TGT_PRED]),
    .ld_size_en(ld_psize),
    .ld_size   (set_word[23:18]),
    .base_q    (pbase_q),
    .size_q    (psize_q)
  );

  lrc_reg_base #(.RW(RB_W), .FW(FLD_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step[TGT_REG]),
    .ld_en (ld_rbase),
    .f_cur (set_word[17:12]),
    .f_size(set_word[11:6]),
    .f_rot (set_word[5:0]),
    .base_q(rbase_q),
    .size_q(rsize_q),
    .rot_q (rrot_q)
  );

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_valid && !ld_stat && !ld_rbase && !ld_psize) |=>
      ($stable(stat_q) && $stable(pbase_q) && $stable(psize_q) &&
       $stable(rbase_q) && $stable(rsize_q) && $stable(rrot_q)));

  a_r2_outcome_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !ld_stat && br_taken && !ctl_word[16]) |=> $stable(stat_q));
endmodule

// File: tb/loop_rot_commit_tb_top.sv
module loop_rot_commit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        commit_valid = 1'b0;
  logic [31:0] ctl_word = '0;
  logic        br_taken = 1'b0;
  logic        ld_stat = 1'b0;
  logic [63:0] stat_data = '0;
  logic        ld_rbase = 1'b0;
  logic        ld_psize = 1'b0;
  logic [31:0] set_word = '0;
  logic [63:0] stat_q;
  logic [5:0]  pbase_q, psize_q;
  logic [7:0]  rbase_q, rsize_q, rrot_q;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [63:0] m_stat;
  logic [5:0]  m_pb, m_ps;
  logic [7:0]  m_rb, m_rs, m_rr;

  always #2 clk = ~clk;

  loop_rot_commit dut_i (
    .clk(clk), .rst_n(rst_n), .commit_valid(commit_valid), .ctl_word(ctl_word),
    .br_taken(br_taken), .ld_stat(ld_stat), .stat_data(stat_data),
    .ld_rbase(ld_rbase), .ld_psize(ld_psize), .set_word(set_word),
    .stat_q(stat_q), .pbase_q(pbase_q), .psize_q(psize_q),
    .rbase_q(rbase_q), .rsize_q(rsize_q), .rrot_q(rrot_q)
  );

  function automatic logic [63:0] f_loop(input logic [63:0] s, input logic req);
    logic [63:0] r = s;
    if (req && s[31:0] != 0) begin
      r[31:0] = s[31:0] - 32'd1;
      if (s[31:0] == 32'd1) r[51] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [5:0] f_pred(input logic [5:0] b, input logic [5:0] sz);
    logic [5:0] m = b - 6'd1;
    return (m < sz) ? m : sz;
  endfunction

  function automatic logic [7:0] f_reg(input logic [7:0] b, input logic [7:0] sz);
    logic [7:0] s = b + 8'd2;
    return (s >= sz) ? s - sz : s;
  endfunction

  task automatic chk64(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk64(tag, "stat",  stat_q,  m_stat);
    chk64(tag, "pbase", 64'(pbase_q), 64'(m_pb));
    chk64(tag, "psize", 64'(psize_q), 64'(m_ps));
    chk64(tag, "rbase", 64'(rbase_q), 64'(m_rb));
    chk64(tag, "rsize", 64'(rsize_q), 64'(m_rs));
    chk64(tag, "rrot",  64'(rrot_q),  64'(m_rr));
  endtask

  task automatic cyc(input logic cv, input logic [31:0] cw, input logic tk,
                     input logic ls, input logic [63:0] sd, input logic lr,
                     input logic lp, input logic [31:0] sw, input string tag);
    logic rq_l, rq_p, rq_r;
    @(negedge clk);
    commit_valid = cv; ctl_word = cw; br_taken = tk; ld_stat = ls;
    stat_data = sd; ld_rbase = lr; ld_psize = lp; set_word = sw;
    rq_l = cv && (tk ? cw[16] : cw[17]);
    rq_p = cv && (tk ? cw[18] : cw[19]);
    rq_r = cv && (tk ? cw[21] : cw[22]);
    @(posedge clk);
    #1;
    m_stat = ls ? sd : f_loop(m_stat, rq_l);
    if (rq_p) m_pb = f_pred(m_pb, m_ps);
    if (lp) m_ps = sw[23:18];
    if (lr) begin
      m_rb = {1'b0, sw[17:12], 1'b0};
      m_rs = {1'b0, sw[11:6], 1'b0} + 8'd2;
      m_rr = {1'b0, sw[5:0], 1'b0};
    end else if (rq_r) m_rb = f_reg(m_rb, m_rs);
    check_all(tag);
  endtask

  function automatic logic [31:0] rb_word(input int cur, input int sz, input int rot);
    return {14'd0, 6'(cur), 6'(sz), 6'(rot)};
  endfunction

  initial begin : watchdog
    #400000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    int seed = 32'h1234_5678;
    void'($urandom(seed));
    m_stat = '0; m_pb = '0; m_ps = '0; m_rb = '0; m_rs = '0; m_rr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1; check_all("R1");

    // R10 load status with upper bits, overflow bit clear
    cyc(0, 0, 0, 1, 64'h00A5_0000_0000_0003, 0, 0, 0, "R10");
    // R2 taken bit16
    cyc(1, 32'h1 << 16, 1, 0, 0, 0, 0, 0, "R2");
    // R2 bit17 with taken outcome: no effect
    cyc(1, 32'h1 << 17, 1, 0, 0, 0, 0, 0, "R2");
    // R2 bit16 with not-taken outcome: no effect
    cyc(1, 32'h1 << 16, 0, 0, 0, 0, 0, 0, "R2");
    // R2 bit17 not taken -> count 1
    cyc(1, 32'h1 << 17, 0, 0, 0, 0, 0, 0, "R2");
    // R4 count 1 -> 0, overflow set
    cyc(1, 32'h1 << 16, 1, 0, 0, 0, 0, 0, "R4");
    chk64("R4", "ovf bit", 64'(stat_q[51]), 64'd1);
    // R3 at zero stays zero, flag kept
    cyc(1, 32'h3 << 16, 1, 0, 0, 0, 0, 0, "R3");
    // R9 predicate size load
    cyc(0, 0, 0, 0, 0, 0, 1, 32'd5 << 18, "R9");
    // R6 zero wraps to size, then decrement
    cyc(1, 32'h1 << 18, 1, 0, 0, 0, 0, 0, "R6");
    cyc(1, 32'h1 << 19, 0, 0, 0, 0, 0, 0, "R5");
    cyc(1, 32'h1 << 19, 1, 0, 0, 0, 0, 0, "R5");
    // R8 register-base group load
    cyc(0, 0, 0, 0, 0, 1, 0, rb_word(3, 3, 7), "R8");
    // R7 6+2 = 8 >= 8 -> 0, then 2
    cyc(1, 32'h1 << 21, 1, 0, 0, 0, 0, 0, "R7");
    cyc(1, 32'h1 << 22, 0, 0, 0, 0, 0, 0, "R7");
    cyc(1, 32'h1 << 22, 1, 0, 0, 0, 0, 0, "R7");
    // R11 loads beat steps; predicate step uses old size
    cyc(1, 32'h0065_0000, 1, 1, 64'h0000_0001_0000_0009, 1, 1,
        (32'd9 << 18) | rb_word(10, 20, 1), "R11");
    // R12 no commit: nothing changes
    cyc(0, 32'hFFFF_FFFF, 1, 0, 0, 0, 0, 0, "R12");
    cyc(0, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, "R12");
    // R12 unrelated control bits ignored
    cyc(1, 32'hFF90_FFFF, 1, 0, 0, 0, 0, 0, "R12");
    cyc(1, 32'hFF90_FFFF, 0, 0, 0, 0, 0, 0, "R12");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] cw = $urandom;
      logic [63:0] sd = {$urandom, 32'($urandom_range(0, 6))};
      cyc(($urandom_range(0, 9) != 0), cw, 1'($urandom),
          ($urandom_range(0, 15) == 0), sd, ($urandom_range(0, 11) == 0),
          ($urandom_range(0, 11) == 0), $urandom, "R2/R5/R7 random");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule